// File: doc/BRIEF.md
# Cascadable Interrupt Controller Slice

This block collects thirty-two interrupt sources into two request lines for a processor. Each source has its own enable bit, sense polarity, level-or-edge selection and a routing bit that steers it to a normal or an urgent request line. When a source becomes active, its pending bit is latched. Software reads the pending bits over a simple register bus and clears them by writing ones. A masked view reports which pending sources are also enabled. The two request lines are the OR of the masked view, split by the routing bit, and each is registered.

Every raw source first passes through a two-flop synchroniser. Polarity is then applied, and the result is either used as a level or compared with its value one cycle earlier to detect an edge. Because the request lines are registered and active-high, the normal request line of one slice can drive a source input of a parent slice. That parent input is set up as an active-high level source, which gives a two-level tree of controllers.

Top module: `irq_slice`

## Requirements
- R1: After reset, the enable, routing, polarity and sense-type registers read 0, and both request lines are low.
- R2: Source n (port bit `src_in[n]`) occupies bit 31-n of every per-source register, so source 0 is the most significant bit.
- R3: Writing the pending register (offset 0) clears each bit written as 1. Bits written as 0 keep their value.
- R4: A sense-type bit of 0 selects level sensing. An active level sets the pending bit again while the input stays active, so a clear only sticks after the input goes inactive. A pending bit stays latched after the input goes inactive.
- R5: A sense-type bit of 1 selects edge sensing. Only the transition into the active state sets the pending bit, and a clear sticks while the input is held active.
- R6: A polarity bit of 1 means active-high or rising. A polarity bit of 0 means active-low or falling.
- R7: The masked register (offset 5) reads as pending AND enable. Clearing an enable bit hides the source but leaves its pending bit latched.
- R8: The normal request line equals the OR of (masked AND NOT routing), and the urgent line equals the OR of (masked AND routing). Each is registered one cycle after the masked value.
- R9: If a source sets its pending bit in the same cycle that software writes a 1 to clear it, the bit stays set.
- R10: An input change becomes visible in the pending register after the third rising clock edge that samples it, and not after the second.
- R11: The register offsets are: pending 0, enable 1, routing 2, polarity 3, sense type 4, masked 5 (read-only; writes are ignored). Offsets 6 and 7 read 0, and reads with `bus_sel` low return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_in | input | 32 | Raw interrupt sources; bit n is source n |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as the access |
| irq_noncrit | output | 1 | Normal request line (registered) |
| irq_crit | output | 1 | Urgent request line (registered) |

## Verification
A wrong pending bit shows on the request lines one cycle after it reaches the masked view, and it shows on a read of offset 0 or 5 at once. For this reason, every scenario reads the pending register right after the stimulus settles. A fault in the synchroniser or detector moves the moment the pending bit appears, so one test samples between the second and third edges. Two further checks target collisions and sticky behaviour, where an error shows up as a bit that disappears or one that refuses to clear: a clear written in the same cycle as an edge, and a clear written while a level input is still active.

// File: rtl/irq_pkg.sv
// Shared constants for the interrupt controller slice.
// Assumes a register bus with a 3-bit offset and one bit per source.
package irq_pkg;
    localparam int ADDR_W = 3;
    localparam logic [ADDR_W-1:0] OFS_PEND   = 3'd0;
    localparam logic [ADDR_W-1:0] OFS_EN     = 3'd1;
    localparam logic [ADDR_W-1:0] OFS_ROUTE  = 3'd2;
    localparam logic [ADDR_W-1:0] OFS_POL    = 3'd3;
    localparam logic [ADDR_W-1:0] OFS_SENSE  = 3'd4;
    localparam logic [ADDR_W-1:0] OFS_MASKED = 3'd5;
endpackage

// File: rtl/irq_sync.sv
// Two-flop synchroniser for a vector of asynchronous sources.
// Assumes each bit is an independent level and resets to 0.
module irq_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] d_sync
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    // Purpose: move the raw inputs through two flops into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= d_async;
            stage2_q <= stage1_q;
        end
    end

    assign d_sync = stage2_q;
endmodule

// File: rtl/irq_detect.sv
// Polarity adjustment plus level/edge detection, one bit per source.
// Assumes inputs are synchronised and already in register bit order.
// Produces a set request for the pending register each cycle.
module irq_detect #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl_sync,
    input  logic [W-1:0] pol,
    input  logic [W-1:0] sense,
    output logic [W-1:0] set_vec
);
    logic [W-1:0] active;
    logic [W-1:0] active_q;

    // Purpose: a polarity bit of 1 keeps the level; 0 inverts it.
    always_comb begin
        active = ~(lvl_sync ^ pol);
    end

    // Purpose: remember last cycle's active state for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) active_q <= '0;
        else        active_q <= active;
    end

    // Purpose: per source, pick a level or a transition as the set event.
    for (genvar i = 0; i < W; i++) begin : g_det
        always_comb begin
            if (sense[i]) set_vec[i] = active[i] & ~active_q[i];
            else          set_vec[i] = active[i];
        end
    end

    // R5: with the sense type unchanged, an edge source never sets two cycles running
    p_edge_no_repeat_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(sense) && $past(rst_n)) |->
        ((set_vec & sense & $past(set_vec & sense)) == '0));
endmodule

// File: rtl/irq_regs.sv
// Register file: pending (write-one-to-clear), enable, routing,
// polarity, sense type and the read-only masked view.
// Assumes single-cycle bus writes and combinational reads.
// A set request beats a clear of the same bit in the same cycle.
module irq_regs
    import irq_pkg::*;
#(
    parameter int W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      bus_rdata,
    input  logic [W-1:0]      set_vec,
    output logic [W-1:0]      en_q,
    output logic [W-1:0]      route_q,
    output logic [W-1:0]      pol_q,
    output logic [W-1:0]      sense_q,
    output logic [W-1:0]      masked
);
    logic [W-1:0] pend_q;
    logic [W-1:0] clr_mask;
    logic         wr_pend;
    logic         wr_any;

    // Purpose: decode write strobes.
    always_comb begin
        wr_any   = bus_sel & bus_we;
        wr_pend  = wr_any & (bus_addr == OFS_PEND);
        clr_mask = wr_pend ? bus_wdata : '0;
    end

    // Purpose: latch set events and apply write-one-to-clear; set has priority.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~clr_mask) | set_vec;
    end

    // Purpose: plain read/write control registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= '0;
            route_q <= '0;
            pol_q   <= '0;
            sense_q <= '0;
        end else if (wr_any) begin
            case (bus_addr)
                OFS_EN:    en_q    <= bus_wdata;
                OFS_ROUTE: route_q <= bus_wdata;
                OFS_POL:   pol_q   <= bus_wdata;
                OFS_SENSE: sense_q <= bus_wdata;
                default:   ;
            endcase
        end
    end

    // Purpose: masked view of enabled pending sources.
    always_comb begin
        masked = pend_q & en_q;
    end

    // Purpose: read multiplexer.
    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_we) begin
            case (bus_addr)
                OFS_PEND:   bus_rdata = pend_q;
                OFS_EN:     bus_rdata = en_q;
                OFS_ROUTE:  bus_rdata = route_q;
                OFS_POL:    bus_rdata = pol_q;
                OFS_SENSE:  bus_rdata = sense_q;
                OFS_MASKED: bus_rdata = masked;
                default:    bus_rdata = '0;
            endcase
        end
    end

    // R3: bits written as 1 without a simultaneous set are clear next cycle
    p_w1c_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pend |=> ((pend_q & $past(bus_wdata & ~set_vec)) == '0));

    // R3: without a pending write and without set events, pending holds
    p_pend_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_pend && set_vec == '0) |=> (pend_q == $past(pend_q)));

    // R9: every set request is present in pending on the next cycle
    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec != '0) |=> ((pend_q & $past(set_vec)) == $past(set_vec)));
endmodule

// File: rtl/irq_out.sv
// Registered request-line generation from the masked view and routing bits.
// Assumes active-high outputs suitable for driving a parent slice input.
module irq_out #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] masked,
    input  logic [W-1:0] route,
    output logic         irq_noncrit,
    output logic         irq_crit
);
    // Purpose: OR-reduce each routed group and register it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_noncrit <= 1'b0;
            irq_crit    <= 1'b0;
        end else begin
            irq_noncrit <= |(masked & ~route);
            irq_crit    <= |(masked & route);
        end
    end

    // R8: normal line follows the non-routed masked bits by one cycle
    p_noncrit_line_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (irq_noncrit == $past(|(masked & ~route))));

    // R8: urgent line follows the routed masked bits by one cycle
    p_crit_line_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (irq_crit == $past(|(masked & route))));
endmodule

// File: rtl/irq_slice.sv
// Top of the interrupt controller slice. Maps source n to register bit
// N_SRC-1-n, synchronises, detects, latches and drives two request lines.
// Assumes a synchronous active-low reset held for at least two cycles.
module irq_slice
    import irq_pkg::*;
#(
    parameter int N_SRC = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  src_in,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [N_SRC-1:0]  bus_wdata,
    output logic [N_SRC-1:0]  bus_rdata,
    output logic              irq_noncrit,
    output logic              irq_crit
);
    localparam int MSB = N_SRC - 1;

    logic [N_SRC-1:0] src_msb_first;
    logic [N_SRC-1:0] lvl_sync;
    logic [N_SRC-1:0] set_vec;
    logic [N_SRC-1:0] en_q;
    logic [N_SRC-1:0] route_q;
    logic [N_SRC-1:0] pol_q;
    logic [N_SRC-1:0] sense_q;
    logic [N_SRC-1:0] masked;

    // Purpose: R2 bit ordering, source n lands on register bit MSB-n.
    for (genvar n = 0; n < N_SRC; n++) begin : g_order
        assign src_msb_first[MSB-n] = src_in[n];
    end

    irq_sync #(.W(N_SRC)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (src_msb_first),
        .d_sync  (lvl_sync)
    );

    irq_detect #(.W(N_SRC)) u_detect (
        .clk      (clk),
        .rst_n    (rst_n),
        .lvl_sync (lvl_sync),
        .pol      (pol_q),
        .sense    (sense_q),
        .set_vec  (set_vec)
    );

    irq_regs #(.W(N_SRC)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .set_vec   (set_vec),
        .en_q      (en_q),
        .route_q   (route_q),
        .pol_q     (pol_q),
        .sense_q   (sense_q),
        .masked    (masked)
    );

    irq_out #(.W(N_SRC)) u_out (
        .clk         (clk),
        .rst_n       (rst_n),
        .masked      (masked),
        .route       (route_q),
        .irq_noncrit (irq_noncrit),
        .irq_crit    (irq_crit)
    );
endmodule

// File: tb/irq_slice_tb.sv
`timescale 1ns/100ps
module irq_slice_tb;
    localparam logic [2:0] A_PEND = 3'd0, A_EN = 3'd1, A_ROUTE = 3'd2,
                           A_POL = 3'd3, A_SENSE = 3'd4, A_MASKED = 3'd5;
    localparam logic [31:0] B3  = 32'h1000_0000;  // source 3
    localparam logic [31:0] B5  = 32'h0400_0000;  // source 5
    localparam logic [31:0] B7  = 32'h0100_0000;  // source 7
    localparam logic [31:0] B10 = 32'h0020_0000;  // source 10

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src = '1;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_noncrit;
    logic        irq_crit;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    irq_slice u_dut (
        .clk(clk), .rst_n(rst_n), .src_in(src),
        .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_noncrit(irq_noncrit), .irq_crit(irq_crit)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1;
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #0.5;
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rst_n = 1'b0;
        wait_cyc(4);
        rst_n = 1'b1;
        rd(A_EN, d);    check("R1 enable", d, 32'h0);
        rd(A_ROUTE, d); check("R1 routing", d, 32'h0);
        rd(A_POL, d);   check("R1 polarity", d, 32'h0);
        rd(A_SENSE, d); check("R1 sense", d, 32'h0);
        check("R1 lines", {30'h0, irq_noncrit, irq_crit}, 32'h0);
        wait_cyc(6);
        wr(A_PEND, 32'hFFFF_FFFF);
        wait_cyc(2);
        rd(A_PEND, d);  check("R3 clear all", d, 32'h0);
    endtask

    task automatic t_level();
        logic [31:0] d;
        @(negedge clk); src[5] = 1'b0;
        wait_cyc(5);
        rd(A_PEND, d);  check("R2 R4 R6 low level sets bit 26", d, B5);
        rd(A_MASKED, d); check("R7 disabled masked", d, 32'h0);
        check("R8 no line when disabled", {31'h0, irq_noncrit}, 32'h0);
        wr(A_PEND, B5 | 32'h0000_0001);
        wait_cyc(2);
        rd(A_PEND, d);  check("R4 active level re-sets", d, B5);
        @(negedge clk); src[5] = 1'b1;
        wait_cyc(5);
        rd(A_PEND, d);  check("R4 stays latched", d, B5);
        wr(A_PEND, 32'h0);
        wait_cyc(1);
        rd(A_PEND, d);  check("R3 zero write keeps", d, B5);
        wr(A_PEND, B5);
        wait_cyc(2);
        rd(A_PEND, d);  check("R4 clear sticks", d, 32'h0);
    endtask

    task automatic t_edge();
        logic [31:0] d;
        wr(A_SENSE, B3 | B7);
        wr(A_POL, B3);
        wait_cyc(5);
        wr(A_PEND, 32'hFFFF_FFFF);
        wait_cyc(2);
        rd(A_PEND, d);  check("R5 setup clean", d, 32'h0);
        @(negedge clk); src[3] = 1'b0;
        wait_cyc(5);
        rd(A_PEND, d);  check("R6 falling ignored on rising source", d, 32'h0);
        @(negedge clk); src[3] = 1'b1;
        wait_cyc(5);
        rd(A_PEND, d);  check("R5 rising edge sets", d, B3);
        wr(A_PEND, B3);
        wait_cyc(5);
        rd(A_PEND, d);  check("R5 clear sticks while held", d, 32'h0);
        @(negedge clk); src[7] = 1'b0;
        wait_cyc(5);
        rd(A_PEND, d);  check("R6 falling edge sets", d, B7);
        @(negedge clk); src[7] = 1'b1;
        wait_cyc(5);
        wr(A_PEND, B7);
        wait_cyc(2);
        rd(A_PEND, d);  check("R6 cleanup", d, 32'h0);
    endtask

    task automatic t_outputs();
        logic [31:0] d;
        @(negedge clk); src[3] = 1'b0;
        wait_cyc(4);
        @(negedge clk); src[3] = 1'b1;
        wait_cyc(5);
        wr(A_EN, B3);
        rd(A_MASKED, d); check("R7 masked equals pend and enable", d, B3);
        check("R8 line registered one cycle late", {31'h0, irq_noncrit}, 32'h0);
        wait_cyc(2);
        check("R8 normal line", {30'h0, irq_noncrit, irq_crit}, 32'h2);
        wr(A_ROUTE, B3);
        wait_cyc(2);
        check("R8 urgent line", {30'h0, irq_noncrit, irq_crit}, 32'h1);
        wr(A_EN, 32'h0);
        wait_cyc(2);
        rd(A_MASKED, d); check("R7 masked after disable", d, 32'h0);
        check("R7 R8 lines low after disable", {30'h0, irq_noncrit, irq_crit}, 32'h0);
        rd(A_PEND, d);  check("R7 pending kept", d, B3);
        wr(A_EN, B3);
        wr(A_MASKED, 32'hFFFF_FFFF);
        rd(A_MASKED, d); check("R11 masked ignores writes", d, B3);
        rd(A_PEND, d);  check("R11 masked write leaves pending", d, B3);
        rd(3'd6, d);    check("R11 offset 6 reads 0", d, 32'h0);
        rd(3'd7, d);    check("R11 offset 7 reads 0", d, 32'h0);
        rd(A_SENSE, d); check("R11 sense readback", d, B3 | B7);
        rd(A_POL, d);   check("R11 polarity readback", d, B3);
        wr(A_EN, 32'h0);
        wr(A_ROUTE, 32'h0);
        wr(A_PEND, 32'hFFFF_FFFF);
        wait_cyc(2);
        rd(A_PEND, d);  check("R3 cleanup", d, 32'h0);
    endtask

    task automatic t_set_wins();
        logic [31:0] d;
        @(negedge clk); src[3] = 1'b0;
        wait_cyc(5);
        @(negedge clk); src[3] = 1'b1;
        @(posedge clk);
        @(posedge clk);
        wr(A_PEND, B3);
        wait_cyc(2);
        rd(A_PEND, d);  check("R9 set beats clear", d, B3);
        wr(A_PEND, B3);
        wait_cyc(2);
        rd(A_PEND, d);  check("R9 later clear works", d, 32'h0);
    endtask

    task automatic t_latency();
        logic [31:0] d;
        @(negedge clk); src[10] = 1'b0;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        rd(A_PEND, d);  check("R10 not after second edge", d, 32'h0);
        @(negedge clk);
        rd(A_PEND, d);  check("R10 visible after third edge", d, B10);
        src[10] = 1'b1;
        wait_cyc(5);
        wr(A_PEND, B10);
        wait_cyc(2);
        rd(A_PEND, d);  check("R10 cleanup", d, 32'h0);
    endtask

    initial begin
        t_reset();
        t_level();
        t_edge();
        t_outputs();
        t_set_wins();
        t_latency();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=expired expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule